// File: doc/BRIEF.md
# Paired Halfword Saturating Arithmetic Unit

This block is a two-lane SIMD datapath. It treats each 32-bit operand as a pair of independent signed 16-bit halfwords. It adds, subtracts or multiplies the halfwords of one operand with the matching halfwords of the other. Each lane forms its result at double width, so a multiply keeps the full product. The lane then checks that result against the signed 16-bit range. An out-of-range lane either wraps to its low 16 bits or, when saturation is requested, clamps to the nearest limit.

Overflow is recorded in two sticky status bits. One bit belongs to addition and subtraction, and the other belongs to multiplication. Both bits stay set until software-side logic pulses the clear input. A strobe launches each operation. The packed result, the updated status bits and an output strobe appear on the next clock edge. Opcode 3 is a no-operation: it returns zero and leaves the status bits alone.

Top module: `pair_sat_alu`

## Requirements
- R1: After reset, `out_valid` is 0, `result` is 0, and both `ovf_addsub` and `ovf_mul` are 0.
- R2: The low lane uses operand bits 15:0 and the high lane uses bits 31:16. Each lane's result occupies the same bits in `result`. Nothing carries or borrows from one lane into the other.
- R3: The opcode values are 0 = add (a+b), 1 = subtract (a-b) and 2 = multiply (a*b), applied to each lane as signed 16-bit values. When `in_valid` is high at a rising edge, `result` shows the outcome after that edge and `out_valid` is high for that one cycle.
- R4: A lane overflows when its double-width intermediate lies above 32767 or below -32768. For a multiply, the intermediate is the full signed 32-bit product.
- R5: With `sat_en`=1, a lane that overflows positive returns 0x7FFF and a lane that overflows negative returns 0x8000.
- R6: With `sat_en`=0, an overflowing lane returns the low 16 bits of its intermediate.
- R7: An overflow in either lane of an add or subtract sets `ovf_addsub`. An overflow in either lane of a multiply sets `ovf_mul` and leaves `ovf_addsub` unchanged. Saturation does not suppress either flag.
- R8: The flags are sticky. A set flag stays set until `flag_clr` is sampled high, which clears both flags at that edge whether or not `in_valid` is high. An overflow accepted in the same cycle as the clear leaves its own flag set.
- R9: Opcode 3 returns a result of 0 and changes neither flag.
- R10: While `in_valid` is low, `out_valid` is 0 and `result` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Launches one operation |
| opcode | input | 2 | 0 add, 1 subtract, 2 multiply, 3 no-op |
| sat_en | input | 1 | Clamp out-of-range lanes when 1 |
| op_a | input | 32 | First packed halfword operand |
| op_b | input | 32 | Second packed halfword operand |
| flag_clr | input | 1 | Clears both sticky flags |
| out_valid | output | 1 | Result is new this cycle |
| result | output | 32 | Packed halfword result |
| ovf_addsub | output | 1 | Sticky overflow flag for add/subtract |
| ovf_mul | output | 1 | Sticky overflow flag for multiply |

## Verification
The add patterns include a low lane that wraps through zero next to a small high-lane sum, so any carry leaking between lanes shows up. Values one step past each limit are run with and without saturation. These cases separate clamping from wrapping, and positive overflow from negative overflow. The multiply patterns include products far outside 16 bits whose low halves are zero, and the most-negative squared case. These cases expose a design that checks only the low bits or confuses the sign of the overflow. Further sequences set one flag and then run the other operation class, a no-op, an idle cycle and a clear coinciding with an overflow, to show which flag each event may touch.

// File: rtl/pha_pkg.sv
package pha_pkg;
  typedef enum logic [1:0] {
    PH_ADD = 2'd0,
    PH_SUB = 2'd1,
    PH_MUL = 2'd2,
    PH_NOP = 2'd3
  } ph_op_e;
endpackage

// File: rtl/pha_lane.sv
module pha_lane
  import pha_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  ph_op_e       op,
  input  logic         sat,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam int IW = 2 * W;
  localparam logic signed [IW-1:0] MAXV = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [IW-1:0] MINV = ~MAXV;

  logic signed [W-1:0]  a_s, b_s;
  logic signed [IW-1:0] wide;
  logic                 above, below;

  assign a_s = a;
  assign b_s = b;

  always_comb begin
    unique case (op)
      PH_ADD:  wide = IW'(a_s) + IW'(b_s);
      PH_SUB:  wide = IW'(a_s) - IW'(b_s);
      PH_MUL:  wide = IW'(a_s) * IW'(b_s);
      default: wide = '0;
    endcase
  end

  assign above = (wide > MAXV);
  assign below = (wide < MINV);
  assign ovf   = above | below;

  always_comb begin
    if (ovf && sat) begin
      res = above ? MAXV[W-1:0] : MINV[W-1:0];
    end else begin
      res = wide[W-1:0];
    end
  end
endmodule

// File: rtl/pha_flags.sv
module pha_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set_addsub,
  input  logic set_mul,
  output logic ovf_addsub,
  output logic ovf_mul
);
  logic as_d, mul_d;

  always_comb begin
    as_d  = (clr ? 1'b0 : ovf_addsub) | set_addsub;
    mul_d = (clr ? 1'b0 : ovf_mul)    | set_mul;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_addsub <= 1'b0;
      ovf_mul    <= 1'b0;
    end else begin
      ovf_addsub <= as_d;
      ovf_mul    <= mul_d;
    end
  end
endmodule

// File: rtl/pair_sat_alu.sv
module pair_sat_alu
  import pha_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        opcode,
  input  logic              sat_en,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              flag_clr,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              ovf_addsub,
  output logic              ovf_mul
);
  ph_op_e            op;
  logic [DATA_W-1:0] res_d;
  logic [LANES-1:0]  lane_ovf;
  logic              any_ovf;
  logic              set_as, set_mu;
  logic              vld_d;
  logic [DATA_W-1:0] res_nxt;

  assign op = ph_op_e'(opcode);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pha_lane #(.W(LANE_W)) u_lane (
      .a   (op_a[g*LANE_W +: LANE_W]),
      .b   (op_b[g*LANE_W +: LANE_W]),
      .op  (op),
      .sat (sat_en),
      .res (res_d[g*LANE_W +: LANE_W]),
      .ovf (lane_ovf[g])
    );
  end

  assign any_ovf = |lane_ovf;
  assign set_as  = in_valid && any_ovf && (op == PH_ADD || op == PH_SUB);
  assign set_mu  = in_valid && any_ovf && (op == PH_MUL);

  pha_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (flag_clr),
    .set_addsub (set_as),
    .set_mul    (set_mu),
    .ovf_addsub (ovf_addsub),
    .ovf_mul    (ovf_mul)
  );

  always_comb begin
    vld_d   = in_valid;
    res_nxt = in_valid ? res_d : result;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= vld_d;
      result    <= res_nxt;
    end
  end
endmodule

// File: rtl/pha_checker.sv
module pha_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        opcode,
  input logic              flag_clr,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              ovf_addsub,
  input logic              ovf_mul
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result)); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_clr && ovf_addsub) |=> ovf_addsub); // R8
  AST_MUL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_clr && ovf_mul) |=> ovf_mul); // R8
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !in_valid) |=> !ovf_addsub && !ovf_mul); // R8
  AST_NOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 2'd3) |=> result == '0); // R9
  AST_NOP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 2'd3 && !flag_clr) |=> $stable(ovf_addsub) && $stable(ovf_mul)); // R9
  AST_MUL_SEPARATE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 2'd2 && !flag_clr) |=> $stable(ovf_addsub)); // R7
endmodule

bind pair_sat_alu pha_checker #(.DATA_W(DATA_W)) u_pha_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .opcode     (opcode),
  .flag_clr   (flag_clr),
  .out_valid  (out_valid),
  .result     (result),
  .ovf_addsub (ovf_addsub),
  .ovf_mul    (ovf_mul)
);

// File: tb/test_pair_sat_alu.sv
module test_pair_sat_alu;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  opcode;
  logic        sat_en;
  logic [31:0] op_a, op_b;
  logic        flag_clr;
  logic        out_valid;
  logic [31:0] result;
  logic        ovf_addsub, ovf_mul;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit exp_fa = 0;
  bit exp_fm = 0;

  pair_sat_alu i_pair_sat_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .sat_en(sat_en), .op_a(op_a), .op_b(op_b), .flag_clr(flag_clr),
    .out_valid(out_valid), .result(result),
    .ovf_addsub(ovf_addsub), .ovf_mul(ovf_mul)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic void lane_model(input logic [15:0] a, input logic [15:0] b,
                                     input int op, input bit sat,
                                     output logic [15:0] r, output bit ovf);
    int ia, ib, x;
    ia = int'($signed(a));
    ib = int'($signed(b));
    case (op)
      0: x = ia + ib;
      1: x = ia - ib;
      2: x = ia * ib;
      default: x = 0;
    endcase
    ovf = (x > 32767) || (x < -32768);
    if (ovf && sat) r = (x > 0) ? 16'h7FFF : 16'h8000;
    else            r = x[15:0];
  endfunction

  // Launch one operation, then check result, strobe and flags against the model.
  task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                        input int op, input bit sat, input bit clr);
    logic [15:0] r0, r1;
    bit o0, o1;
    lane_model(a[15:0], b[15:0], op, sat, r0, o0);
    lane_model(a[31:16], b[31:16], op, sat, r1, o1);
    if (clr) begin exp_fa = 0; exp_fm = 0; end
    if ((o0 || o1) && (op == 0 || op == 1)) exp_fa = 1;
    if ((o0 || o1) && op == 2) exp_fm = 1;
    @(negedge clk);
    in_valid = 1; op_a = a; op_b = b; opcode = 2'(op); sat_en = sat; flag_clr = clr;
    @(negedge clk);
    in_valid = 0; flag_clr = 0;
    check(req, "out_valid", 32'(out_valid), 32'd1);
    check(req, "result", result, {r1, r0});
    check(req, "ovf_addsub", 32'(ovf_addsub), 32'(exp_fa));
    check(req, "ovf_mul", 32'(ovf_mul), 32'(exp_fm));
  endtask

  task automatic clear_flags();
    @(negedge clk);
    flag_clr = 1;
    @(negedge clk);
    flag_clr = 0;
    exp_fa = 0; exp_fm = 0;
    check("R8", "cleared ovf_addsub", 32'(ovf_addsub), 32'd0);
    check("R8", "cleared ovf_mul", 32'(ovf_mul), 32'd0);
  endtask

  task automatic t_reset();
    check("R1", "out_valid", 32'(out_valid), 32'd0);
    check("R1", "result", result, 32'd0);
    check("R1", "ovf_addsub", 32'(ovf_addsub), 32'd0);
    check("R1", "ovf_mul", 32'(ovf_mul), 32'd0);
  endtask

  task automatic t_lanes();
    run_op("R2", 32'h0003_FFFF, 32'h0002_0001, 0, 0, 0);  // low wraps to 0, high 5
    check("R2", "no carry across lanes", result, 32'h0005_0000);
    run_op("R3", 32'h0010_0005, 32'h0003_0007, 1, 0, 0);  // sub
    check("R3", "sub packed", result, 32'h000D_FFFE);
    run_op("R3", 32'h0003_FFFD, 32'hFFFC_0004, 2, 0, 0);  // mul small
    check("R3", "mul packed", result, 32'hFFF4_FFF4);
  endtask

  task automatic t_addsub_ovf();
    run_op("R5", 32'h7FFF_0001, 32'h0002_0001, 0, 1, 0);
    check("R5", "pos clamp", result, 32'h7FFF_0002);
    check("R7", "add sets addsub", 32'(ovf_addsub), 32'd1);
    check("R7", "add leaves mul", 32'(ovf_mul), 32'd0);
    run_op("R6", 32'h7FFF_0001, 32'h0002_0001, 0, 0, 0);
    check("R6", "pos wrap", result, 32'h8001_0002);
    run_op("R5", 32'h0000_8000, 32'h0000_0001, 1, 1, 0);
    check("R5", "neg clamp", result, 32'h0000_8000);
    run_op("R6", 32'h0000_8000, 32'h0000_0002, 1, 0, 0);
    check("R6", "neg wrap", result, 32'h0000_7FFE);
    run_op("R4", 32'h7FFE_8001, 32'h0001_FFFF, 0, 1, 0);   // exactly at limits
    check("R4", "limits not overflow", result, 32'h7FFF_8000);
  endtask

  task automatic t_mul_ovf();
    clear_flags();
    run_op("R4", 32'h0100_FF00, 32'h0100_0100, 2, 1, 0);
    check("R4", "mul full product clamp", result, 32'h7FFF_8000);
    check("R7", "mul sets mul flag", 32'(ovf_mul), 32'd1);
    check("R7", "mul leaves addsub", 32'(ovf_addsub), 32'd0);
    run_op("R6", 32'h0100_8000, 32'h0100_8000, 2, 0, 0);
    check("R6", "mul wrap low bits", result, 32'h0000_0000);
    run_op("R5", 32'h0000_8000, 32'h0000_8000, 2, 1, 0);
    check("R5", "min squared clamp", result, 32'h0000_7FFF);
  endtask

  task automatic t_sticky();
    run_op("R8", 32'h0001_0001, 32'h0001_0001, 0, 0, 0);  // no overflow
    check("R8", "mul flag persists", 32'(ovf_mul), 32'd1);
    clear_flags();
    run_op("R8", 32'h7FFF_0000, 32'h0001_0000, 0, 1, 1);  // clear + overflow
    check("R8", "new flag survives clear", 32'(ovf_addsub), 32'd1);
  endtask

  task automatic t_nop_idle();
    logic [31:0] held;
    run_op("R9", 32'h7FFF_7FFF, 32'h7FFF_7FFF, 3, 1, 0);
    check("R9", "nop zero", result, 32'd0);
    check("R9", "nop flags", {30'd0, ovf_addsub, ovf_mul}, 32'd2);
    run_op("R10", 32'h1234_0001, 32'h0001_0001, 0, 0, 0);
    held = result;
    @(negedge clk);
    op_a = 32'h7FFF_7FFF; op_b = 32'h7FFF_7FFF; opcode = 2'd2;
    @(negedge clk);
    check("R10", "idle strobe low", 32'(out_valid), 32'd0);
    check("R10", "idle result held", result, held);
    check("R10", "idle mul flag", 32'(ovf_mul), 32'd0);
  endtask

  initial begin
    rst_n = 0; in_valid = 0; opcode = 0; sat_en = 0;
    op_a = 0; op_b = 0; flag_clr = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_lanes();
    t_addsub_ovf();
    t_mul_ovf();
    t_sticky();
    t_nop_idle();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end
endmodule